// File: doc/BRIEF.md
# Truncating Linear Congruential Generator

This block produces a stream of pseudorandom words of width N. Each word is the previous word multiplied by a multiplier A, plus an increment C, modulo 2^N. The modulus is a power of two, so the reduction costs no logic at all. The product and the sum are each kept to their low N bits. There is no subtractor and no comparator. The increment is a real operand and may be any value, including zero.

The seed, the multiplier and the increment come from input ports. Three operand registers capture them while the generator is idle (enable low) and hold them while it runs. On the first clock with enable high, a two-way selector loads the captured seed into the state register. On every later clock it loads the truncated next value instead. The state register drives the output directly. A synchronous active-low reset clears it and takes priority over enable. Dropping enable freezes the output. Raising enable again restarts the sequence from the seed captured most recently.

Top module: `lcg_trunc_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, the output and all operand registers clear to zero, whatever the value of en.
- R2: On the first rising edge with en high after en was low (or after reset), the output becomes the seed value captured last.
- R3: On each later rising edge with en still high, the output becomes (mult * out + incr) mod 2^N. The product and the sum are both truncated to N bits, and this holds for N = 8, 16 and 31.
- R4: With N = 8, seed 7, multiplier 3 and increment 1, the output runs 7, 22, 67, 202, 95 on consecutive edges.
- R5: While en is low and rst_n is high, the output holds its value.
- R6: Operands are captured on every edge with en low. Changes on seed_i, mult_i and incr_i while en is high have no effect on the running sequence.
- R7: Lowering en and raising it again reloads the output from the seed, using the operands captured while en was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, priority over en |
| en | input | 1 | High: run the generator; low: hold output and capture operands |
| seed_i | input | N | Starting value of the sequence |
| mult_i | input | N | Multiplier A |
| incr_i | input | N | Increment C |
| rnd_o | output | N | Current generator state |

## Verification
Five operand sets are run through generators of width 8, 16 and 31 side by side, and each output is compared with a model that wraps at the matching width. The all-ones set forces both the product and the sum past 2^N, so it exposes any missing truncation. The zero-multiplier set separates the increment path from the multiplier path, and the unit-multiplier, zero-increment set must hold the seed constant. Directed tests change the operands mid-run, pause and restart with fresh operands, and assert reset while enable is high. Together they tell operand freezing, seed reload and reset priority apart.

// File: rtl/lcg_pkg.sv
// Shared definitions for the truncating congruential generator.
// Assumes operand slots are indexed by the enum below.
package lcg_pkg;
    typedef enum int {
        OP_SEED = 0,
        OP_MULT = 1,
        OP_INCR = 2
    } lcg_op_e;

    localparam int NUM_OPS = 3;
endpackage

// File: rtl/lcg_operand_regs.sv
// Operand registers: one per operand slot, loaded on every edge while
// en is low and frozen while en is high. Assumes synchronous active-low reset.
module lcg_operand_regs #(
    parameter int N = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en,
    input  logic [lcg_pkg::NUM_OPS-1:0][N-1:0]  op_d,
    output logic [lcg_pkg::NUM_OPS-1:0][N-1:0]  op_q
);
    for (genvar g = 0; g < lcg_pkg::NUM_OPS; g++) begin : g_op
        // Capture one operand while idle; hold it while running.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op_q[g] <= '0;
            end else if (!en) begin
                op_q[g] <= op_d[g];
            end
        end

        // R6: operands cannot move while the generator runs
        a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (en && $past(rst_n)) |=> $stable(op_q[g]));
    end
endmodule

// File: rtl/lcg_next_state.sv
// Next-state arithmetic: low N bits of mult*state, plus incr, wrapped to
// N bits. Purely combinational; the modulus 2^N is implicit in the width.
module lcg_next_state #(
    parameter int N = 8
) (
    input  logic [N-1:0] state_i,
    input  logic [N-1:0] mult_i,
    input  logic [N-1:0] incr_i,
    output logic [N-1:0] next_o
);
    logic [N-1:0] prod_lo;

    // Multiply and add, each keeping only the low N bits.
    always_comb begin
        prod_lo = mult_i * state_i;
        next_o  = prod_lo + incr_i;
    end
endmodule

// File: rtl/lcg_state_reg.sv
// State register with seed selector. The first enabled edge loads the seed;
// later enabled edges load the next value. Holds while en is low.
// Synchronous active-low reset has priority over en.
module lcg_state_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] seed_i,
    input  logic [N-1:0] next_i,
    output logic [N-1:0] state_o,
    output logic         running_o
);
    logic [N-1:0] state_q;
    logic         running_q;
    logic [N-1:0] load_val;

    // Selector between the registered seed and the fed-back value.
    always_comb begin
        load_val = running_q ? next_i : seed_i;
    end

    // State and run flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= '0;
            running_q <= 1'b0;
        end else if (en) begin
            state_q   <= load_val;
            running_q <= 1'b1;
        end else begin
            running_q <= 1'b0;
        end
    end

    assign state_o   = state_q;
    assign running_o = running_q;

    // R1: reset clears the state regardless of en
    a_r1_clear: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0));

    // R2: first enabled edge loads the seed
    a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !running_q) |=> (state_q == $past(seed_i)));

    // R3: later enabled edges load the computed next value
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running_q) |=> (state_q == $past(next_i)));

    // R5: state holds while en is low
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en && rst_n) |-> (state_q == $past(state_q)));
endmodule

// File: rtl/lcg_trunc_gen.sv
// Top of the truncating congruential generator: operand capture, next-state
// arithmetic and seed-selecting state register. Width N is a parameter.
module lcg_trunc_gen #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] seed_i,
    input  logic [N-1:0] mult_i,
    input  logic [N-1:0] incr_i,
    output logic [N-1:0] rnd_o
);
    import lcg_pkg::*;

    logic [NUM_OPS-1:0][N-1:0] op_d;
    logic [NUM_OPS-1:0][N-1:0] op_q;
    logic [N-1:0]              next_val;
    logic [N-1:0]              state;
    logic                      running;

    // Pack the operand inputs into slot order.
    always_comb begin
        op_d[OP_SEED] = seed_i;
        op_d[OP_MULT] = mult_i;
        op_d[OP_INCR] = incr_i;
    end

    lcg_operand_regs #(.N(N)) u_ops (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .op_d  (op_d),
        .op_q  (op_q)
    );

    lcg_next_state #(.N(N)) u_next (
        .state_i (state),
        .mult_i  (op_q[OP_MULT]),
        .incr_i  (op_q[OP_INCR]),
        .next_o  (next_val)
    );

    lcg_state_reg #(.N(N)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .seed_i    (op_q[OP_SEED]),
        .next_i    (next_val),
        .state_o   (state),
        .running_o (running)
    );

    assign rnd_o = state;

    // R1: operands are cleared by reset as well
    a_r1_ops_clear: assert property (@(posedge clk)
        !rst_n |=> (op_q == '0));
endmodule

// File: tb/lcg_trunc_gen_tb.sv
module lcg_trunc_gen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [7:0]  s8,  a8,  c8,  o8;
    logic [15:0] s16, a16, c16, o16;
    logic [30:0] s31, a31, c31, o31;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lcg_trunc_gen #(.N(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .seed_i(s8), .mult_i(a8), .incr_i(c8), .rnd_o(o8));
    lcg_trunc_gen #(.N(16)) u_dut16 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .seed_i(s16), .mult_i(a16), .incr_i(c16), .rnd_o(o16));
    lcg_trunc_gen #(.N(31)) u_dut31 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .seed_i(s31), .mult_i(a31), .incr_i(c31), .rnd_o(o31));

    localparam int NV = 5;
    localparam logic [92:0] VEC [NV] = '{
        {31'd7,          31'd3,          31'd1},
        {31'h7FFFFFFF,   31'h7FFFFFFF,   31'h7FFFFFFF},
        {31'd12345,      31'd1103515245, 31'd12345},
        {31'd1,          31'd0,          31'd5},
        {31'd5,          31'd1,          31'd0}
    };
    localparam int STEPS = 6;

    function automatic longint unsigned step(longint unsigned x, longint unsigned a,
                                             longint unsigned c, longint unsigned m);
        return ((a * x) + c) & m;
    endfunction

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(logic [30:0] s, logic [30:0] a, logic [30:0] c);
        s8 = s[7:0];   a8 = a[7:0];   c8 = c[7:0];
        s16 = s[15:0]; a16 = a[15:0]; c16 = c[15:0];
        s31 = s;       a31 = a;       c31 = c;
    endtask

    task automatic check_all(string tag, longint unsigned e8, longint unsigned e16,
                             longint unsigned e31);
        check({tag, " N8"},  64'(o8),  e8);
        check({tag, " N16"}, 64'(o16), e16);
        check({tag, " N31"}, 64'(o31), e31);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        longint unsigned x8, x16, x31, hold8;
        apply(31'd9, 31'd9, 31'd9);
        // R1: reset with en high clears outputs
        @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 reset with en high", 0, 0, 0);
        en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 idle after reset", 0, 0, 0);

        // R2 R3: vector table on all widths
        for (int i = 0; i < NV; i++) begin
            logic [30:0] vs, va, vc;
            vs = VEC[i][92:62];
            va = VEC[i][61:31];
            vc = VEC[i][30:0];
            en = 1'b0;
            apply(vs, va, vc);
            @(negedge clk);
            en = 1'b1;
            @(negedge clk);
            x8 = vs & 64'hFF; x16 = vs & 64'hFFFF; x31 = vs;
            check_all($sformatf("R2 seed vec%0d", i), x8, x16, x31);
            for (int k = 0; k < STEPS; k++) begin
                @(negedge clk);
                x8  = step(x8,  va & 64'hFF,   vc & 64'hFF,   64'hFF);
                x16 = step(x16, va & 64'hFFFF, vc & 64'hFFFF, 64'hFFFF);
                x31 = step(x31, va,            vc,            64'h7FFFFFFF);
                check_all($sformatf("R3 vec%0d step%0d", i, k), x8, x16, x31);
            end
        end

        // R4: literal sequence for N=8
        en = 1'b0;
        apply(31'd7, 31'd3, 31'd1);
        @(negedge clk);
        en = 1'b1;
        begin
            longint unsigned lit [5] = '{7, 22, 67, 202, 95};
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check($sformatf("R4 N8 item%0d", k), 64'(o8), lit[k]);
            end
        end

        // R6: change inputs while running; sequence keeps old operands
        x8 = 95;
        apply(31'd50, 31'd5, 31'd9);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            x8 = step(x8, 3, 1, 64'hFF);
            check($sformatf("R6 ignore inputs step%0d", k), 64'(o8), x8);
        end

        // R5: hold while en low (operands now capture 50,5,9)
        en = 1'b0;
        hold8 = x8;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check($sformatf("R5 hold cycle%0d", k), 64'(o8), hold8);
        end

        // R7: re-enable reloads new seed, then uses new operands
        en = 1'b1;
        @(negedge clk);
        check("R7 reload seed", 64'(o8), 50);
        @(negedge clk);
        check("R7 new operands step", 64'(o8), step(50, 5, 9, 64'hFF));

        // R1: reset mid-run with en high
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 mid-run reset", 0, 0, 0);
        rst_n = 1'b1;
        en = 1'b0;
        @(negedge clk);
        check("R1 stays clear after release", 64'(o8), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule